// File: doc/BRIEF.md
# LCD panel scan timing generator

This block produces the raster timing for a parallel RGB LCD panel: horizontal sync, vertical sync, a data-enable that marks visible pixels, and the current pixel column and row inside the visible area. Line and frame geometry come from two packed 32-bit timing words. The block steps once for every cycle in which an external pixel-clock enable is high, so one system clock can drive panels of any pixel rate.

A run-enable input starts and stops the raster. While it is low, all counters sit at the first pixel of the sync region. A separate power input gates the three panel pins. Each pin has its own polarity-invert bit. The usual order is to raise enable and then power when starting, and to drop power and then enable when stopping. The timing words are changed only while enable is low.

A vertical-compare event marks the moment the frame enters one of four selectable vertical phases. It appears as a one-cycle pulse and sets a sticky status bit. The status bit is cleared by a write-one-to-clear input and reaches the interrupt output only when a mask bit is set.

Top module: `lcd_scan_timer`

## Requirements
- R1: Each line runs through sync, back porch, active and front porch, in that order. With the horizontal word `htim`, the sync region lasts htim[15:8]+1 pixel ticks and the back porch lasts htim[31:24]+1. The active region lasts (htim[7:2]+1)*16 ticks and the front porch lasts htim[23:16]+1. hsync (before inversion) is high exactly during the sync region.
- R2: Lines group into frames in the same order, counted in whole lines. With the vertical word `vtim`, the sync region lasts vtim[15:10]+1 lines and the back porch lasts vtim[31:24] lines. The active region lasts vtim[9:0]+1 lines and the front porch lasts vtim[23:16] lines. A porch of length zero is skipped. vsync (before inversion) is high during the sync lines.
- R3: de (before inversion) is high only when both axes are in their active regions. px gives the pixel offset inside the horizontal active region and reads 0 outside it. py gives the line offset inside the vertical active region and reads 0 outside it.
- R4: The raster advances by one pixel only on clock edges where pix_ce is high. With pix_ce low, px and py hold.
- R5: While en is low, the raster is held at line 0, pixel 0 of the sync region. The un-inverted hsync, vsync and de are low, and px and py are 0. The first pix_ce tick after en rises moves to pixel 1.
- R6: inv_hs, inv_vs and inv_de each invert their own pin (1 = inverted).
- R7: While pwr is low, hsync, vsync and de are all driven 0, whatever the inversion bits are.
- R8: irq_pulse is high for one clock cycle right after the vertical phase changes into the phase chosen by irq_sel: 0 = sync, 1 = back porch, 2 = active, 3 = front porch. It only fires while en is high. A skipped porch never fires.
- R9: irq_stat is set one cycle after irq_pulse is high. Otherwise it is cleared one cycle after irq_clr is high, so a set wins over a clear. It resets to 0. irq_out equals irq_stat AND irq_mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_ce | input | 1 | Pixel-clock enable; one raster step per high cycle |
| en | input | 1 | Run enable; low holds the raster at its start |
| pwr | input | 1 | Panel power; low forces all pins to 0 |
| htim | input | 32 | Horizontal timing word (fields per R1) |
| vtim | input | 32 | Vertical timing word (fields per R2) |
| inv_hs | input | 1 | Invert hsync |
| inv_vs | input | 1 | Invert vsync |
| inv_de | input | 1 | Invert de |
| irq_sel | input | 2 | Vertical phase that raises the compare event |
| irq_mask | input | 1 | Interrupt mask (1 = pass) |
| irq_clr | input | 1 | Write-one-to-clear for irq_stat |
| hsync | output | 1 | Horizontal sync pin |
| vsync | output | 1 | Vertical sync pin |
| de | output | 1 | Data-enable pin |
| px | output | XW | Active pixel column |
| py | output | YW | Active line row |
| irq_pulse | output | 1 | One-cycle vertical-compare pulse |
| irq_stat | output | 1 | Sticky vertical-compare status |
| irq_out | output | 1 | Masked interrupt |

## Verification
The assertions assume that htim and vtim stay steady while en is high, since the length checks only hold while the geometry is frozen. They place no limit on how often pix_ce, irq_clr or en toggle. The stimulus changes the timing words, polarity bits, power and irq_sel only during idle stretches with en low. It drives pix_ce as constant-high, every third cycle, or from a pseudo-random bit, and pulses irq_clr at a fixed period unrelated to the frame. Two geometries are swept: one with both vertical porches present and one with both set to zero. Each geometry is run under every compare phase and every pix_ce pattern for more than two frames.

// File: rtl/lcd_scan_timer.sv
module lcd_scan_timer #(
  parameter int XW = 10,
  parameter int YW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_ce,
  input  logic          en,
  input  logic          pwr,
  input  logic [31:0]   htim,
  input  logic [31:0]   vtim,
  input  logic          inv_hs,
  input  logic          inv_vs,
  input  logic          inv_de,
  input  logic [1:0]    irq_sel,
  input  logic          irq_mask,
  input  logic          irq_clr,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic [XW-1:0] px,
  output logic [YW-1:0] py,
  output logic          irq_pulse,
  output logic          irq_stat,
  output logic          irq_out
);
  localparam int LW  = XW + 1;
  localparam int VLW = YW + 1;
  localparam logic [1:0] P_SYN = 2'd0;
  localparam logic [1:0] P_BPO = 2'd1;
  localparam logic [1:0] P_ACT = 2'd2;
  localparam logic [1:0] P_FPO = 2'd3;

  logic [1:0]     hph, vph, vph_prev;
  logic [LW-1:0]  hcnt, hlen;
  logic [VLW-1:0] vcnt, vlen;
  logic [1:0]     vnext;
  logic           h_last, v_last, line_end;
  logic           unused_bits;

  assign unused_bits = ^htim[1:0];

  always_comb begin
    case (hph)
      P_SYN:   hlen = LW'(htim[15:8]) + LW'(1);
      P_BPO:   hlen = LW'(htim[31:24]) + LW'(1);
      P_ACT:   hlen = (LW'(htim[7:2]) + LW'(1)) << 4;
      default: hlen = LW'(htim[23:16]) + LW'(1);
    endcase
  end

  always_comb begin
    case (vph)
      P_SYN: begin
        vlen  = VLW'(vtim[15:10]) + VLW'(1);
        vnext = (vtim[31:24] != 8'd0) ? P_BPO : P_ACT;
      end
      P_BPO: begin
        vlen  = VLW'(vtim[31:24]);
        vnext = P_ACT;
      end
      P_ACT: begin
        vlen  = VLW'(vtim[9:0]) + VLW'(1);
        vnext = (vtim[23:16] != 8'd0) ? P_FPO : P_SYN;
      end
      default: begin
        vlen  = VLW'(vtim[23:16]);
        vnext = P_SYN;
      end
    endcase
  end

  assign h_last   = (hcnt == hlen - LW'(1));
  assign v_last   = (vcnt == vlen - VLW'(1));
  assign line_end = en & pix_ce & h_last & (hph == P_FPO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hph  <= P_SYN;
      hcnt <= '0;
    end else if (!en) begin
      hph  <= P_SYN;
      hcnt <= '0;
    end else if (pix_ce) begin
      if (h_last) begin
        hph  <= hph + 2'd1;
        hcnt <= '0;
      end else begin
        hcnt <= hcnt + LW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vph  <= P_SYN;
      vcnt <= '0;
    end else if (!en) begin
      vph  <= P_SYN;
      vcnt <= '0;
    end else if (line_end) begin
      if (v_last) begin
        vph  <= vnext;
        vcnt <= '0;
      end else begin
        vcnt <= vcnt + VLW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vph_prev <= P_SYN;
      irq_stat <= 1'b0;
    end else begin
      vph_prev <= vph;
      if (irq_pulse)    irq_stat <= 1'b1;
      else if (irq_clr) irq_stat <= 1'b0;
    end
  end

  assign irq_pulse = en & (vph != vph_prev) & (vph == irq_sel);
  assign irq_out   = irq_stat & irq_mask;

  assign hsync = pwr & ((en & (hph == P_SYN)) ^ inv_hs);
  assign vsync = pwr & ((en & (vph == P_SYN)) ^ inv_vs);
  assign de    = pwr & ((en & (hph == P_ACT) & (vph == P_ACT)) ^ inv_de);
  assign px    = (hph == P_ACT) ? hcnt[XW-1:0] : '0;
  assign py    = (vph == P_ACT) ? vcnt[YW-1:0] : '0;
endmodule

module lcd_scan_timer_chk #(
  parameter int XW = 10,
  parameter int YW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pix_ce,
  input logic          en,
  input logic          pwr,
  input logic          hsync,
  input logic          vsync,
  input logic          de,
  input logic [XW-1:0] px,
  input logic [YW-1:0] py,
  input logic          irq_pulse,
  input logic          irq_clr,
  input logic          irq_stat
);
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse);
  a_r8_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> en);
  a_r9_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> irq_stat);
  a_r9_clears_status: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !irq_pulse) |=> !irq_stat);
  a_r7_power_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr |-> (!hsync && !vsync && !de));
  a_r4_hold_position: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !pix_ce) |=> ($stable(px) && $stable(py)));
  a_r5_idle_origin: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (px == '0 && py == '0));
endmodule

bind lcd_scan_timer lcd_scan_timer_chk #(.XW(XW), .YW(YW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pix_ce(pix_ce), .en(en), .pwr(pwr),
  .hsync(hsync), .vsync(vsync), .de(de), .px(px), .py(py),
  .irq_pulse(irq_pulse), .irq_clr(irq_clr), .irq_stat(irq_stat)
);

// File: tb/sim_lcd_scan_timer.sv
module sim_lcd_scan_timer;
  localparam int XW = 10;
  localparam int YW = 10;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, pix_ce = 1'b0, en = 1'b0, pwr = 1'b0;
  logic [31:0] htim = '0, vtim = '0;
  logic inv_hs = 1'b0, inv_vs = 1'b0, inv_de = 1'b0;
  logic [1:0] irq_sel = 2'd0;
  logic irq_mask = 1'b0, irq_clr = 1'b0;
  logic hsync, vsync, de, irq_pulse, irq_stat, irq_out;
  logic [XW-1:0] px;
  logic [YW-1:0] py;

  lcd_scan_timer #(.XW(XW), .YW(YW)) u0 (
    .clk(clk), .rst_n(rst_n), .pix_ce(pix_ce), .en(en), .pwr(pwr),
    .htim(htim), .vtim(vtim), .inv_hs(inv_hs), .inv_vs(inv_vs),
    .inv_de(inv_de), .irq_sel(irq_sel), .irq_mask(irq_mask),
    .irq_clr(irq_clr), .hsync(hsync), .vsync(vsync), .de(de),
    .px(px), .py(py), .irq_pulse(irq_pulse), .irq_stat(irq_stat),
    .irq_out(irq_out)
  );

  int checks = 0, failures = 0;
  bit done = 1'b0;
  int hs, hb, ha, hf, vs, vb, va, vf;
  int k = 0, pvph = 0, pat = 0, cyc = 0;
  bit pulse_p = 1'b0, clr_p = 1'b0, stat_e = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d tick=%0d", tag, act, exp, k);
    end
  endtask

  task automatic locate(input int pos, input int s, input int b, input int a,
                        output int ph, output int off);
    if (pos < s)              begin ph = 0; off = pos; end
    else if (pos < s + b)     begin ph = 1; off = pos - s; end
    else if (pos < s + b + a) begin ph = 2; off = pos - s - b; end
    else                      begin ph = 3; off = pos - s - b - a; end
  endtask

  task automatic set_cfg(input int s1, input int b1, input int a1, input int f1,
                         input int s2, input int b2, input int a2, input int f2);
    hs = s1; hb = b1; ha = a1; hf = f1;
    vs = s2; vb = b2; va = a2; vf = f2;
    htim = {8'(hb - 1), 8'(hf - 1), 8'(hs - 1), 6'(ha / 16 - 1), 2'b00};
    vtim = {8'(vb), 8'(vf), 6'(vs - 1), 10'(va - 1)};
  endtask

  task automatic check_all(output bit cond);
    int L, F, pos, hph, hoff, vph, voff;
    int e_hs, e_vs, e_de;
    string sx;
    L = hs + hb + ha + hf;
    F = vs + vb + va + vf;
    pos = k % (L * F);
    locate(pos % L, hs, hb, ha, hph, hoff);
    locate(pos / L, vs, vb, va, vph, voff);
    stat_e = pulse_p ? 1'b1 : (clr_p ? 1'b0 : stat_e);
    cond = (vph != pvph) && (vph == int'(irq_sel));
    sx = "";
    if (!pwr) sx = {sx, "/R7"};
    if (!en) sx = {sx, "/R5"};
    if (inv_hs || inv_vs || inv_de) sx = {sx, "/R6"};
    if (pat != 0) sx = {sx, "/R4"};
    e_hs = pwr ? (int'(en && hph == 0) ^ int'(inv_hs)) : 0;
    e_vs = pwr ? (int'(en && vph == 0) ^ int'(inv_vs)) : 0;
    e_de = pwr ? (int'(en && hph == 2 && vph == 2) ^ int'(inv_de)) : 0;
    chk({"R1 hsync", sx}, int'(hsync), e_hs);
    chk({"R2 vsync", sx}, int'(vsync), e_vs);
    chk({"R3 de", sx}, int'(de), e_de);
    chk({"R3 px", sx}, int'(px), (hph == 2) ? hoff : 0);
    chk({"R3 py", sx}, int'(py), (vph == 2) ? voff : 0);
    chk({"R8 irq_pulse", sx}, int'(irq_pulse), int'(en && cond));
    chk({"R9 irq_stat", sx}, int'(irq_stat), int'(stat_e));
    chk({"R9 irq_out", sx}, int'(irq_out), int'(stat_e && irq_mask));
    pvph = vph;
  endtask

  task automatic step(input bit n_en);
    bit cond, n_ce;
    @(negedge clk);
    check_all(cond);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (pat)
      0:       n_ce = 1'b1;
      1:       n_ce = lfsr[0];
      default: n_ce = (cyc % 3 == 0);
    endcase
    en = n_en;
    pix_ce = n_ce;
    irq_clr = (cyc % 53 == 0);
    cyc++;
    pulse_p = cond && n_en;
    clr_p = irq_clr;
    if (!n_en) k = 0;
    else if (n_ce) k++;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    set_cfg(2, 3, 16, 1, 1, 1, 3, 2);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7 reset hsync", int'(hsync), 0);
    chk("R7 reset vsync", int'(vsync), 0);
    chk("R7 reset de", int'(de), 0);
    chk("R5 reset px", int'(px), 0);
    chk("R5 reset py", int'(py), 0);
    chk("R9 reset irq_stat", int'(irq_stat), 0);
    for (int cfg = 0; cfg < 2; cfg++) begin
      for (int sel = 0; sel < 4; sel++) begin
        for (int p = 0; p < 3; p++) begin
          int frame;
          step(1'b0);
          if (cfg == 0) set_cfg(2, 3, 16, 1, 1, 1, 3, 2);
          else          set_cfg(1, 1, 32, 4, 2, 0, 2, 0);
          pat = p;
          irq_sel = 2'(sel);
          irq_mask = sel[1];
          inv_hs = sel[0];
          inv_vs = cfg[0];
          inv_de = p[0];
          pwr = !(cfg == 1 && sel == 2);
          for (int i = 0; i < 5; i++) step(1'b0);
          frame = (hs + hb + ha + hf) * (vs + vb + va + vf);
          while (k < 2 * frame + 20) step(1'b1);
        end
      end
    end
    for (int i = 0; i < 4; i++) step(1'b0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule